// File: doc/BRIEF.md
# Double-Buffered Attenuation Register Bank

This block keeps the volume-attenuation settings for eight audio output channels, arranged as four stereo pairs. Software-side logic writes to it through a one-cycle write port that carries an address, an 8-bit attenuation code and an update flag. Each write first goes into a pending register for the addressed channel. The active codes that drive the outputs change only when a write carries the update flag, and then every channel takes its pending value in the same cycle. A gain change that spans several channels therefore reaches all of them together.

A master address writes the same code into every pending register at once. A pair-follow mode input makes each right channel present the active code of its left partner. The mode changes nothing that is stored, so clearing it brings back each right channel's own setting. The bank presents only the eight active codes. The serial control link, readback and the audio path are outside this block.

Top module: `atten_bank`

## Requirements
- R1: While reset is held and afterwards until the first committing write, every pending and active code is 0xFF (0 dB), so every output reads 0xFF.
- R2: A write to channel address k (k = 0..7, with addresses ordered L0, R0, L1, R1, L2, R2, L3, R3) with the update flag at 0 loads only that channel's pending register. No output changes.
- R3: A write to any mapped address (0..8) with the update flag at 1 copies every channel's pending code into its active register on that clock edge. The new codes appear at the outputs after that edge.
- R4: The update flag is not remembered. A later write with the flag at 0 does not commit anything, even if an earlier write carried the flag at 1.
- R5: A write to the master address 8 loads the code into the pending registers of all eight channels. With the flag at 1, all eight outputs then show that code.
- R6: While the follow input is 1, each right output (odd index) shows the active code of the left channel below it, and left outputs are unaffected. While it is 0, every output shows its own active code. The input acts combinationally and leaves stored codes intact.
- R7: A write to an unmapped address (9..15) is ignored. It loads no pending register and commits nothing, even with the update flag at 1.
- R8: When a channel write carries the update flag, the code committed for that channel is the one carried by the same write, not its previous pending value.
- R9: While the write enable is 0, the address, data and update inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 4 | Write address: 0..7 channels, 8 master |
| wrData | input | 8 | Attenuation code to store |
| wrUpdate | input | 1 | Commit all pending codes with this write |
| rightFollowsLeft | input | 1 | Right channels present their left partner's code |
| attenOut | output | 64 | Eight presented codes, channel k in bits 8k+7..8k |

## Verification
The bench stages a different pending code on every channel without the update flag. This exposes a design that lets a staged write reach the outputs early, or one that commits only the written channel instead of all of them. It commits through a channel write whose own code differs from that channel's older pending value, which catches a design that commits the stale value. It then checks that a later write without the flag leaves the outputs alone, which catches a design that stores the flag. It also writes to an unmapped address with the flag set, and sends a fully loaded write while the enable is low. A later commit then shows whether any pending register was corrupted by either write. The follow mode is switched on and off over asymmetric left and right codes, so a design that overwrites the stored right codes would fail to restore them.

// File: rtl/atten_pkg.sv
package atten_pkg;

  // Strobes handed from the write decoder to the register datapath.
  typedef struct packed {
    logic loadAll;   // master address hit: every pending register loads
    logic loadOne;   // a single channel address hit
    logic commit;    // copy all pending codes into the active registers
  } atten_strobe_t;

endpackage

// File: rtl/atten_ctrl.sv
module atten_ctrl
  import atten_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 0
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrUpdate,
  output atten_strobe_t     strobe,
  output logic [NUM_CH-1:0] chanSel
);

  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(BASE_ADDR + NUM_CH);

  logic masterHit;

  // One comparator per channel address, consecutive from BASE_ADDR.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign chanSel[i] = wrEn && (wrAddr == ADDR_W'(BASE_ADDR + i));
  end

  assign masterHit = wrEn && (wrAddr == MASTER_ADDR);

  always_comb begin
    strobe.loadAll = masterHit;
    strobe.loadOne = |chanSel;
    // Update acts only on a mapped write; unmapped writes are dropped whole.
    strobe.commit  = wrUpdate && (masterHit || (|chanSel));
  end

endmodule

// File: rtl/atten_datapath.sv
module atten_datapath
  import atten_pkg::*;
#(
  parameter int                  NUM_CH     = 8,
  parameter int                  ATTEN_W    = 8,
  parameter logic [ATTEN_W-1:0]  RESET_CODE = '1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  atten_strobe_t               strobe,
  input  logic [NUM_CH-1:0]           chanSel,
  input  logic [ATTEN_W-1:0]          wrData,
  output logic [NUM_CH*ATTEN_W-1:0]   activeFlat
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [ATTEN_W-1:0] pendQ;
    logic [ATTEN_W-1:0] activeQ;
    logic [ATTEN_W-1:0] pendNext;

    // Pending value as it will be after this cycle's write; committing
    // from it lets a same-cycle write reach the active register directly.
    always_comb begin
      pendNext = pendQ;
      if (strobe.loadAll || (strobe.loadOne && chanSel[i])) pendNext = wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ   <= RESET_CODE;
        activeQ <= RESET_CODE;
      end else begin
        pendQ <= pendNext;
        if (strobe.commit) activeQ <= pendNext;
      end
    end

    assign activeFlat[i*ATTEN_W +: ATTEN_W] = activeQ;
  end

endmodule

// File: rtl/atten_pairmux.sv
module atten_pairmux #(
  parameter int NUM_PAIRS = 4,
  parameter int ATTEN_W   = 8
) (
  input  logic                             followLeft,
  input  logic [2*NUM_PAIRS*ATTEN_W-1:0]   activeFlat,
  output logic [2*NUM_PAIRS*ATTEN_W-1:0]   outFlat
);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int L = (2*p)   * ATTEN_W;
    localparam int R = (2*p+1) * ATTEN_W;
    assign outFlat[L +: ATTEN_W] = activeFlat[L +: ATTEN_W];
    assign outFlat[R +: ATTEN_W] = followLeft ? activeFlat[L +: ATTEN_W]
                                              : activeFlat[R +: ATTEN_W];
  end

endmodule

// File: rtl/atten_bank.sv
module atten_bank
  import atten_pkg::*;
#(
  parameter int                  NUM_PAIRS  = 4,
  parameter int                  ATTEN_W    = 8,
  parameter int                  ADDR_W     = 4,
  parameter int                  BASE_ADDR  = 0,
  parameter logic [ATTEN_W-1:0]  RESET_CODE = '1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [ATTEN_W-1:0]                wrData,
  input  logic                              wrUpdate,
  input  logic                              rightFollowsLeft,
  output logic [2*NUM_PAIRS*ATTEN_W-1:0]    attenOut
);

  localparam int NUM_CH = 2 * NUM_PAIRS;

  atten_strobe_t              strobe;
  logic [NUM_CH-1:0]          chanSel;
  logic [NUM_CH*ATTEN_W-1:0]  activeFlat;

  atten_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrUpdate(wrUpdate),
    .strobe(strobe), .chanSel(chanSel)
  );

  atten_datapath #(
    .NUM_CH(NUM_CH), .ATTEN_W(ATTEN_W), .RESET_CODE(RESET_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanSel(chanSel),
    .wrData(wrData), .activeFlat(activeFlat)
  );

  atten_pairmux #(
    .NUM_PAIRS(NUM_PAIRS), .ATTEN_W(ATTEN_W)
  ) u_mux (
    .followLeft(rightFollowsLeft), .activeFlat(activeFlat), .outFlat(attenOut)
  );

endmodule

// File: rtl/atten_bank_chk.sv
module atten_bank_chk #(
  parameter int                  NUM_PAIRS  = 4,
  parameter int                  ATTEN_W    = 8,
  parameter int                  ADDR_W     = 4,
  parameter int                  BASE_ADDR  = 0,
  parameter logic [ATTEN_W-1:0]  RESET_CODE = '1
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              wrEn,
  input logic [ADDR_W-1:0]                 wrAddr,
  input logic [ATTEN_W-1:0]                wrData,
  input logic                              wrUpdate,
  input logic                              rightFollowsLeft,
  input logic [2*NUM_PAIRS*ATTEN_W-1:0]    attenOut,
  input logic [2*NUM_PAIRS*ATTEN_W-1:0]    activeFlat
);

  localparam int NUM_CH = 2 * NUM_PAIRS;
  localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(BASE_ADDR + NUM_CH);

  logic mapped;
  assign mapped = (int'(wrAddr) >= BASE_ADDR) && (int'(wrAddr) <= BASE_ADDR + NUM_CH);

  // R1: reset leaves every active code at the reset code.
  p_reset_code_r1: assert property (@(posedge clk)
    !rstN |=> activeFlat == {NUM_CH{RESET_CODE}});

  // R2, R4, R7, R9: without a mapped, enabled, flagged write nothing commits.
  p_hold_no_update_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrUpdate && mapped) |=> $stable(activeFlat));

  // R5: flagged master write sets every channel.
  p_master_commit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrUpdate && wrAddr == MASTER_ADDR)
      |=> activeFlat == {NUM_CH{$past(wrData)}});

  // R8: the value carried by a flagged channel write is what that channel commits.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    p_same_cycle_value_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrUpdate && wrAddr == ADDR_W'(BASE_ADDR + i))
        |=> activeFlat[i*ATTEN_W +: ATTEN_W] == $past(wrData));
  end

  // R6: presentation follows the pair mode.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    p_follow_right_r6: assert property (@(posedge clk) disable iff (!rstN)
      rightFollowsLeft |->
        attenOut[(2*p+1)*ATTEN_W +: ATTEN_W] == activeFlat[(2*p)*ATTEN_W +: ATTEN_W]);
    p_own_right_r6: assert property (@(posedge clk) disable iff (!rstN)
      !rightFollowsLeft |->
        attenOut[(2*p+1)*ATTEN_W +: ATTEN_W] == activeFlat[(2*p+1)*ATTEN_W +: ATTEN_W]);
  end

endmodule

bind atten_bank atten_bank_chk #(
  .NUM_PAIRS(NUM_PAIRS), .ATTEN_W(ATTEN_W), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .RESET_CODE(RESET_CODE)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .wrUpdate(wrUpdate), .rightFollowsLeft(rightFollowsLeft),
  .attenOut(attenOut), .activeFlat(activeFlat)
);

// File: tb/sim_atten_bank.sv
module sim_atten_bank;

  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wrUpdate = 1'b0;
  logic        rightFollowsLeft = 1'b0;
  logic [63:0] attenOut;

  int checks = 0;
  int fails = 0;
  logic [7:0] pend [NCH];
  logic [7:0] act  [NCH];

  always #5 clk = ~clk;

  atten_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrUpdate(wrUpdate), .rightFollowsLeft(rightFollowsLeft), .attenOut(attenOut)
  );

  // Bench model of the requirements; applied when a write is issued.
  task automatic modelWrite(input logic [3:0] a, input logic [7:0] d, input logic u);
    if (a < 4'd8) pend[a] = d;
    else if (a == 4'd8) for (int i = 0; i < NCH; i++) pend[i] = d;
    else return;
    if (u) for (int i = 0; i < NCH; i++) act[i] = pend[i];
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [7:0] d, input logic u);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrUpdate = u;
    @(negedge clk);
    wrEn = 1'b0; wrUpdate = 1'b0;
    modelWrite(a, d, u);
  endtask

  task automatic checkAll(input string req);
    for (int c = 0; c < NCH; c++) begin
      logic [7:0] exp;
      exp = (rightFollowsLeft && c[0]) ? act[c-1] : act[c];
      checks++;
      if (attenOut[c*8 +: 8] !== exp) begin
        fails++;
        $display("FAIL %s ch%0d: actual %02h expected %02h", req, c, attenOut[c*8 +: 8], exp);
      end
    end
  endtask

  task automatic t_reset_r1();
    for (int i = 0; i < NCH; i++) begin pend[i] = 8'hFF; act[i] = 8'hFF; end
    checkAll("R1");
  endtask

  task automatic t_stage_r2();
    for (int i = 0; i < NCH; i++) begin
      doWrite(4'(i), 8'(8'h10 + 8'(i) * 8'h11), 1'b0);
      checkAll("R2");
    end
  endtask

  task automatic t_commit_r3_r8();
    doWrite(4'd3, 8'h40, 1'b1);   // differs from ch3 pending 0x43
    checkAll("R3");
    checks++;
    if (attenOut[3*8 +: 8] !== 8'h40) begin
      fails++;
      $display("FAIL R8 ch3: actual %02h expected 40", attenOut[3*8 +: 8]);
    end
  endtask

  task automatic t_flag_not_kept_r4();
    doWrite(4'd0, 8'h11, 1'b0);
    checkAll("R4");
    doWrite(4'd5, 8'h55, 1'b0);
    checkAll("R4");
    doWrite(4'd6, 8'h66, 1'b1);
    checkAll("R3");
  endtask

  task automatic t_master_r5();
    doWrite(4'd8, 8'h80, 1'b0);
    checkAll("R5");
    doWrite(4'd8, 8'h20, 1'b1);
    checkAll("R5");
  endtask

  task automatic t_unmapped_r7();
    doWrite(4'd1, 8'h31, 1'b0);
    doWrite(4'd12, 8'h99, 1'b1);
    checkAll("R7");
    doWrite(4'd9, 8'h77, 1'b0);
    doWrite(4'd15, 8'h88, 1'b1);
    checkAll("R7");
    doWrite(4'd2, 8'h32, 1'b1);   // commit reveals pending untouched by unmapped writes
    checkAll("R7");
  endtask

  task automatic t_enable_low_r9();
    doWrite(4'd4, 8'h44, 1'b0);
    wrEn = 1'b0; wrAddr = 4'd4; wrData = 8'hC3; wrUpdate = 1'b1;
    @(negedge clk);
    wrUpdate = 1'b0;
    checkAll("R9");
    doWrite(4'd7, 8'h07, 1'b1);
    checkAll("R9");
  endtask

  task automatic t_follow_r6();
    doWrite(4'd0, 8'h0A, 1'b0);
    doWrite(4'd1, 8'hB1, 1'b0);
    doWrite(4'd6, 8'h6C, 1'b0);
    doWrite(4'd7, 8'hF7, 1'b1);
    rightFollowsLeft = 1'b1;
    #1 checkAll("R6");
    @(negedge clk);
    checkAll("R6");
    rightFollowsLeft = 1'b0;
    #1 checkAll("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    t_stage_r2();
    t_commit_r3_r8();
    t_flag_not_kept_r4();
    t_master_r5();
    t_unmapped_r7();
    t_enable_low_r9();
    t_follow_r6();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule